// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between on-chip logic running on a single system clock and an external asynchronous static RAM. A client hands it one access at a time over a valid/ready handshake: address, write data and a write flag. For a read, the block returns the word on a one-cycle read-valid strobe. On the memory side it generates active-low chip-select, write-strobe and output-enable lines and an address bus. The bidirectional data bus is presented as separate output, input and output-enable signals, so the pad ring can build the tri-state driver.

Every analog timing limit is supplied as a parameter in picoseconds together with the clock period. The block rounds each limit up to whole clock cycles and never lets a phase shrink below one cycle. A write is framed by the overlap of chip-select and write-strobe, with the write-strobe rise as the terminating edge. Output-enable stays low from the start of the write, so the memory may still drive the bus just after the write-strobe falls. The controller therefore waits out that release time before driving, and the wait is counted inside the write cycle. After a read, the bus is not driven for a write until the memory has released it.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, rd_valid is 0 and req_ready is 1.
- R2: mem_we_n is low only while mem_ce_n is low. In a write it stays low for exactly HZ+DAT cycles. HZ = ceil(T_WEHZ_PS/CLK_PS). DAT = max(ceil(T_SETUP_PS/CLK_PS), PW-HZ, WC-HZ-1, 1), where PW and WC are the rounded write-pulse and write-cycle limits.
- R3: During a write, mem_dq_oe stays 0 for the first HZ cycles of mem_we_n low. It is then 1 for the remaining DAT cycles of the low pulse and for exactly one cycle after mem_we_n rises, and then returns to 0.
- R4: mem_addr holds the accepted address during the whole access. mem_dq_out does not change while mem_dq_oe stays 1.
- R5: A read holds mem_ce_n and mem_oe_n low and mem_we_n high for exactly ACC cycles. ACC = max of the rounded address-access, output-enable-access and read-cycle limits, and at least 1.
- R6: rd_valid is 1 for exactly one cycle, the cycle right after the last read cycle. In that cycle rd_data equals the value on mem_dq_in at the end of the last read cycle.
- R7: When a write directly follows a read, the high-Z wait of the write lasts max(HZ, REL) cycles, where REL = ceil(T_REL_PS/CLK_PS).
- R8: req_ready falls in the cycle after a request is accepted. It returns to 1 after HZ_eff+DAT+1 cycles for a write (HZ_eff being the high-Z wait of R3 or R7) and after ACC cycles for a read. A request presented in that cycle is accepted at once.
- R9: mem_dq_oe is never 1 while mem_ce_n is 0, mem_oe_n is 0 and mem_we_n is 1, so the controller and the memory never drive the bus together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Client presents an access |
| req_ready | output | 1 | Controller can accept an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle strobe marking returned read data |
| rd_data | output | DW | Returned read data |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | AW | Memory address bus |
| mem_dq_out | output | DW | Data driven toward the memory |
| mem_dq_in | input | DW | Data received from the memory |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |

## Verification
A sequencer stuck in the wrong phase shows up at the strobes within the same access. The write-strobe low time, the undriven stretch at its start or the read-enable window comes out one or more cycles off, and the bench counts these cycle by cycle. A turnaround wait that is lost after a read shows up as the data drivers enabling earlier than max(HZ, REL) cycles into the next write. If the memory still drives at that moment, the contention monitor fires in that cycle. A corrupted address or data register is visible a few cycles later, when the next read of that location returns the wrong word on rd_data.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_WHZ  = 3'd1,
        S_WDAT = 3'd2,
        S_WEND = 3'd3,
        S_RD   = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       ce_n;
        logic       we_n;
        logic       oe_n;
        logic       dq_oe;
    } seq_regs_t;

    // whole clock cycles covering a limit, never below one
    function automatic int to_cycles(input int lim_ps, input int clk_ps);
        int c;
        c = (lim_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // a count that has run out stays out until reloaded
    p_done_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int CW     = 4,
    parameter int HZ_C   = 1,
    parameter int DAT_C  = 1,
    parameter int ACC_C  = 1,
    parameter int REL_C  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          ph_done,
    input  logic          rel_done,
    output logic          req_ready,
    output logic          accept,
    output logic          capture,
    output logic          ph_load,
    output logic [CW-1:0] ph_val,
    output logic          rel_load,
    output logic [CW-1:0] rel_val,
    output logic          ce_n,
    output logic          we_n,
    output logic          oe_n,
    output logic          dq_oe
);
    localparam seq_regs_t IDLE_REGS = '{st: S_IDLE, ce_n: 1'b1, we_n: 1'b1,
                                        oe_n: 1'b1, dq_oe: 1'b0};

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        accept   = 1'b0;
        capture  = 1'b0;
        ph_load  = 1'b0;
        ph_val   = '0;
        rel_load = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    ph_load  = 1'b1;
                    r_d.ce_n = 1'b0;
                    r_d.oe_n = 1'b0;
                    if (req_write) begin
                        r_d.st   = S_WHZ;
                        r_d.we_n = 1'b0;
                        ph_val   = CW'(HZ_C - 1);
                    end else begin
                        r_d.st   = S_RD;
                        ph_val   = CW'(ACC_C - 1);
                    end
                end
            end
            S_WHZ: begin
                if (ph_done && rel_done) begin
                    r_d.st    = S_WDAT;
                    r_d.dq_oe = 1'b1;
                    ph_load   = 1'b1;
                    ph_val    = CW'(DAT_C - 1);
                end
            end
            S_WDAT: begin
                if (ph_done) begin
                    r_d.st   = S_WEND;
                    r_d.we_n = 1'b1;
                    r_d.oe_n = 1'b1;
                end
            end
            S_WEND: begin
                r_d = IDLE_REGS;
            end
            S_RD: begin
                if (ph_done) begin
                    r_d      = IDLE_REGS;
                    capture  = 1'b1;
                    rel_load = 1'b1;
                end
            end
            default: r_d = IDLE_REGS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= IDLE_REGS;
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.st == S_IDLE);
    assign rel_val   = CW'(REL_C);
    assign ce_n      = r_q.ce_n;
    assign we_n      = r_q.we_n;
    assign oe_n      = r_q.oe_n;
    assign dq_oe     = r_q.dq_oe;

    p_we_inside_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);

    p_ready_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_no_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n || !we_n || ce_n));

    // drivers enable only after the write strobe has already been low a cycle
    p_wait_before_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (!we_n && $past(!we_n)));

    // driving continues through the cycle where the strobe rises
    p_hold_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n) && !ce_n) |-> dq_oe);

endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] mem_dq_in,
    input  logic          mem_ce_n,
    input  logic          mem_dq_oe,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          rvalid;
    } dp_regs_t;

    dp_regs_t d_d, d_q;

    always_comb begin
        d_d        = d_q;
        d_d.rvalid = capture;
        if (accept) begin
            d_d.addr  = req_addr;
            d_d.wdata = req_wdata;
        end
        if (capture)
            d_d.rdata = mem_dq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign mem_addr   = d_q.addr;
    assign mem_dq_out = d_q.wdata;
    assign rd_data    = d_q.rdata;
    assign rd_valid   = d_q.rvalid;

    p_rdv_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    p_wdata_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW          = 18,
    parameter int DW          = 16,
    parameter int CLK_PS      = 20000,
    parameter int T_ADDR_PS   = 15000,
    parameter int T_OEACC_PS  = 7000,
    parameter int T_RC_PS     = 15000,
    parameter int T_REL_PS    = 7000,
    parameter int T_WEHZ_PS   = 7000,
    parameter int T_SETUP_PS  = 8000,
    parameter int T_PULSE_PS  = 12000,
    parameter int T_WC_PS     = 15000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_dq_oe
);
    localparam int ACC_C = imax(imax(to_cycles(T_ADDR_PS, CLK_PS),
                                     to_cycles(T_OEACC_PS, CLK_PS)),
                                to_cycles(T_RC_PS, CLK_PS));
    localparam int HZ_C  = to_cycles(T_WEHZ_PS, CLK_PS);
    localparam int PW_C  = to_cycles(T_PULSE_PS, CLK_PS);
    localparam int WC_C  = to_cycles(T_WC_PS, CLK_PS);
    localparam int SD_C  = to_cycles(T_SETUP_PS, CLK_PS);
    localparam int DAT_C = imax(imax(SD_C, PW_C - HZ_C), imax(WC_C - HZ_C - 1, 1));
    localparam int REL_C = to_cycles(T_REL_PS, CLK_PS);
    localparam int MAX_C = imax(imax(ACC_C, HZ_C), imax(DAT_C, REL_C));
    localparam int CW    = $clog2(MAX_C + 1);

    logic          accept, capture;
    logic          ph_load, ph_done, rel_load, rel_done;
    logic [CW-1:0] ph_val, rel_val;

    sram_ctrl_seq #(
        .CW(CW), .HZ_C(HZ_C), .DAT_C(DAT_C), .ACC_C(ACC_C), .REL_C(REL_C)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .ph_done(ph_done), .rel_done(rel_done),
        .req_ready(req_ready), .accept(accept), .capture(capture),
        .ph_load(ph_load), .ph_val(ph_val),
        .rel_load(rel_load), .rel_val(rel_val),
        .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
    );

    sram_ctrl_timer #(.CW(CW)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .load(ph_load), .load_val(ph_val), .done(ph_done)
    );

    sram_ctrl_timer #(.CW(CW)) u_release (
        .clk(clk), .rst_n(rst_n),
        .load(rel_load), .load_val(rel_val), .done(rel_done)
    );

    sram_ctrl_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .req_addr(req_addr), .req_wdata(req_wdata),
        .capture(capture), .mem_dq_in(mem_dq_in),
        .mem_ce_n(mem_ce_n), .mem_dq_oe(mem_dq_oe),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && !mem_ce_n && mem_we_n) |-> !mem_dq_oe);

endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
    localparam int AW = 4;
    localparam int DW = 16;
    // expected cycle counts worked out by hand for a 20 ns clock
    localparam int E_ACC = 3;   // max(ceil(50/20), ceil(20/20), ceil(45/20))
    localparam int E_HZ  = 2;   // ceil(30/20)
    localparam int E_DAT = 3;   // max(2, 4-2, 6-2-1, 1)
    localparam int E_REL = 3;   // ceil(50/20)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid;
    logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    int clashes = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sram_ctrl #(
        .AW(AW), .DW(DW), .CLK_PS(20000),
        .T_ADDR_PS(50000), .T_OEACC_PS(20000), .T_RC_PS(45000),
        .T_REL_PS(50000), .T_WEHZ_PS(30000), .T_SETUP_PS(30000),
        .T_PULSE_PS(70000), .T_WC_PS(120000)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // memory model: reads combinationally, writes on the strobe rise
    logic [DW-1:0] ram [16];
    logic          we_prev = 1'b1;
    wire           ram_drives = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_in = ram_drives ? ram[mem_addr] : '0;

    initial for (int i = 0; i < 16; i++) ram[i] = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_prev && mem_we_n && !mem_ce_n) ram[mem_addr] <= mem_dq_out;
            if (mem_dq_oe && ram_drives) clashes++;
        end
        we_prev <= mem_we_n;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // issue one access at a negedge with ready high; return at the negedge
    // where ready is high again
    task automatic access(input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [DW-1:0] exp,
                          input bit after_read);
        int busy = 0, we_lo = 0, hz = 0, drv = 0, oe_lo = 0, bad_addr = 0;
        int exp_hz;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 ready low after accept", req_ready, 0);
        while (!req_ready && busy < 100) begin
            busy++;
            if (!mem_we_n) we_lo++;
            if (!mem_we_n && !mem_dq_oe) hz++;
            if (mem_dq_oe) drv++;
            if (!mem_oe_n && mem_we_n) oe_lo++;
            if (mem_addr != a) bad_addr++;
            @(negedge clk);
        end
        check("R4 address held", bad_addr, 0);
        if (wr) begin
            exp_hz = after_read ? ((E_HZ > E_REL) ? E_HZ : E_REL) : E_HZ;
            check(after_read ? "R7 turnaround wait" : "R3 high-Z wait", hz, exp_hz);
            check("R2 strobe low length", we_lo, exp_hz + E_DAT);
            check("R3 drive length", drv, E_DAT + 1);
            check("R8 write busy", busy, exp_hz + E_DAT + 1);
        end else begin
            check("R5 read enable window", oe_lo, E_ACC);
            check("R8 read busy", busy, E_ACC);
            check("R6 rd_valid", rd_valid, 1);
            check("R6 rd_data", rd_data, exp);
        end
    endtask

    // {write, addr, wdata, expected read}
    localparam logic [36:0] VEC [9] = '{
        {1'b1, 4'h3, 16'h1234, 16'h0000},
        {1'b1, 4'h7, 16'hABCD, 16'h0000},
        {1'b0, 4'h3, 16'h0000, 16'h1234},
        {1'b0, 4'h7, 16'h0000, 16'hABCD},
        {1'b1, 4'h3, 16'h5555, 16'h0000},
        {1'b0, 4'h3, 16'h0000, 16'h5555},
        {1'b0, 4'h0, 16'h0000, 16'h0000},
        {1'b1, 4'hF, 16'hFFFF, 16'h0000},
        {1'b0, 4'hF, 16'h0000, 16'hFFFF}
    };

    initial begin
        bit prev_rd = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 ce_n in reset", mem_ce_n, 1);
        check("R1 we_n in reset", mem_we_n, 1);
        check("R1 oe_n in reset", mem_oe_n, 1);
        check("R1 dq_oe in reset", mem_dq_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        check("R1 ready idle", req_ready, 1);
        check("R1 rd_valid idle", rd_valid, 0);

        for (int i = 0; i < 9; i++) begin
            access(VEC[i][36], VEC[i][35:32], VEC[i][31:16], VEC[i][15:0], prev_rd);
            prev_rd = !VEC[i][36];
        end

        // R6: strobe lasts a single cycle when no request follows
        @(negedge clk);
        check("R6 rd_valid single cycle", rd_valid, 0);
        check("R6 rd_data kept", rd_data, 16'hFFFF);

        // R7: write after a read with idle gap covering the release time
        access(1'b0, 4'h7, 16'h0, 16'hABCD, 1'b0);
        repeat (4) @(negedge clk);
        access(1'b1, 4'h9, 16'h0F0F, 16'h0, 1'b0);
        access(1'b0, 4'h9, 16'h0, 16'h0F0F, 1'b0);

        // R1: reset in the middle of a write returns everything to idle
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h2; req_wdata = 16'h7777;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 strobes after mid reset",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after mid reset", req_ready, 1);
        check("R9 no bus clash", clashes, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule